// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial peripheral interface slave that gives an external bus master access to a small bank of byte-wide registers. The master lowers the active-low select, clocks a command byte, and then clocks any number of data bytes. The command byte chooses between reading and writing and names a starting register. Each data byte either lands in the current register or is taken from it, and the address then advances by one. Clock polarity and clock phase are inputs, so all four standard modes are supported.

All serial inputs cross into the system clock domain through two-flop synchronizers, and all state lives in that domain. While the command byte is clocked in, the slave returns its status byte, which is register 0. Local logic updates status and reads configuration through a side port. That port has a write strobe with an address and data, and a combinational read of the same address. When an SPI commit and a local write hit the same register in the same cycle, the SPI commit wins.

The MISO output comes as a data bit and an output enable. A pad or a tri-state buffer outside this block turns them into a line that floats whenever the slave is not selected.

Top module: `spi_regbank_slave`

## Requirements
- R1: While `ss_n` is high, `miso_oe` is 0 and `miso_o` is 0, and SCK activity has no effect on any register. While `ss_n` is low, `miso_oe` is 1.
- R2: Mode inputs `cpol` and `cpha` select the SCK idle level and phase. With `cpha`=0, the first MISO bit is valid before the first leading edge, bits are sampled on leading edges and shifted on trailing edges. With `cpha`=1, bits are shifted on leading edges and sampled on trailing edges. Data travels MSB first in every mode.
- R3: During the command byte of every transaction, MISO carries the contents of register 0 (the status byte), MSB first.
- R4: Command byte bit 7 is the direction (1 = read, 0 = write), and bits 6:0 are the starting register address.
- R5: On a write, each following data byte is stored in the current register only once all 8 of its bits have been sampled.
- R6: On a read, each following data byte returned on MISO is the contents of the current register.
- R7: After every data byte, the current address increments by one, modulo 128, so one select period can carry a burst.
- R8: The bank has 16 registers. Addresses 16 to 127 read as 0x00 and ignore writes.
- R9: Raising `ss_n` in the middle of a byte discards the partial byte, with no register change. The next select starts again with a command byte.
- R10: A `loc_we` pulse writes `loc_wdata` into register `loc_addr` at the next clock edge. `loc_rdata` always shows register `loc_addr`.
- R11: After reset, all registers hold 0x00 and MISO is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCK idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| ss_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output enable for MISO (0 = release line) |
| loc_we | input | 1 | Local write strobe |
| loc_addr | input | 4 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Contents of register `loc_addr` |

## Verification
The bench runs writes followed by read-backs in all four modes. If polarity or phase were decoded wrongly, a read-back would come out shifted by one bit or would be an inverted copy. It cuts a write byte after four bits and checks that the target register is untouched. A design that committed early, or kept its bit count across selects, would corrupt that register or misread the next command. Bursts that cross register 15 and the 127-to-0 wrap expose a bad range check or a bad increment, and the status byte is checked on every command so that a missing preload shows up as stale data.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
    localparam int BYTE_W = 8;
    localparam int CMD_AW = 7;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;
endpackage

// File: rtl/spi_sync_chain.sv
module spi_sync_chain #(
    parameter int             WIDTH     = 3,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0][STAGES-1:0] chain_d, chain_q;

    always_comb begin
        for (int b = 0; b < WIDTH; b++) begin
            chain_d[b] = {chain_q[b][STAGES-2:0], din[b]};
            dout[b]    = chain_q[b][STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < WIDTH; b++)
                chain_q[b] <= {STAGES{RESET_VAL[b]}};
        end else begin
            chain_q <= chain_d;
        end
    end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              ss_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic [BYTE_W-1:0] status_byte,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [CMD_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [CMD_AW-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sel,
    output logic              miso_bit
);
    typedef struct packed {
        logic              sck_prev;
        logic              sel_prev;
        logic [2:0]        bit_cnt;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] tx_sh;
        logic [BYTE_W-1:0] nxt;
        logic              pend;
        phase_e            phase;
        logic              rd;
        logic [CMD_AW-1:0] addr;
    } eng_t;

    eng_t st_d, st_q;

    logic              sck_rise, sck_fall, sel_start;
    logic              lead, trail, samp, shft;
    logic [BYTE_W-1:0] rx_byte;

    always_comb begin
        sel       = ~ss_s;
        sck_rise  = sck_s & ~st_q.sck_prev;
        sck_fall  = ~sck_s & st_q.sck_prev;
        sel_start = sel & ~st_q.sel_prev;
        lead      = cpol ? sck_fall : sck_rise;
        trail     = cpol ? sck_rise : sck_fall;
        samp      = cpha ? trail : lead;
        shft      = cpha ? lead : trail;
        rx_byte   = {st_q.rx_sh[BYTE_W-2:0], mosi_s};

        rd_addr   = (st_q.phase == PH_CMD) ? rx_byte[CMD_AW-1:0]
                                           : st_q.addr + CMD_AW'(1);
        wr_addr   = st_q.addr;
        wr_data   = rx_byte;
        wr_en     = 1'b0;
        miso_bit  = st_q.tx_sh[BYTE_W-1];

        st_d          = st_q;
        st_d.sck_prev = sck_s;
        st_d.sel_prev = sel;

        if (!sel) begin
            st_d.bit_cnt = '0;
            st_d.phase   = PH_CMD;
            st_d.pend    = 1'b0;
        end else if (sel_start) begin
            st_d.bit_cnt = '0;
            st_d.phase   = PH_CMD;
            if (cpha) begin
                st_d.pend = 1'b1;
                st_d.nxt  = status_byte;
            end else begin
                st_d.pend  = 1'b0;
                st_d.tx_sh = status_byte;
            end
        end else begin
            if (shft) begin
                if (st_q.pend) begin
                    st_d.tx_sh = st_q.nxt;
                    st_d.pend  = 1'b0;
                end else begin
                    st_d.tx_sh = {st_q.tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
            if (samp) begin
                st_d.rx_sh   = rx_byte;
                st_d.bit_cnt = st_q.bit_cnt + 3'd1;
                if (st_q.bit_cnt == 3'd7) begin
                    st_d.pend = 1'b1;
                    if (st_q.phase == PH_CMD) begin
                        st_d.rd    = rx_byte[BYTE_W-1];
                        st_d.addr  = rx_byte[CMD_AW-1:0];
                        st_d.phase = PH_DATA;
                        st_d.nxt   = rx_byte[BYTE_W-1] ? rd_data : '0;
                    end else begin
                        wr_en     = ~st_q.rd;
                        st_d.addr = st_q.addr + CMD_AW'(1);
                        st_d.nxt  = st_q.rd ? rd_data : '0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sck_prev: 1'b0, sel_prev: 1'b0, bit_cnt: '0,
                      rx_sh: '0, tx_sh: '0, nxt: '0, pend: 1'b0,
                      phase: PH_CMD, rd: 1'b0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store
    import spi_regbank_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int STATUS_ADDR = 0,
    localparam int LOC_AW     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [CMD_AW-1:0] spi_waddr,
    input  logic [BYTE_W-1:0] spi_wdata,
    input  logic [CMD_AW-1:0] spi_raddr,
    output logic [BYTE_W-1:0] spi_rdata,
    input  logic              loc_we,
    input  logic [LOC_AW-1:0] loc_addr,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] loc_rdata,
    output logic [BYTE_W-1:0] status_byte
);
    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (loc_we && int'(loc_addr) == i)
                regs_d[i] = loc_wdata;
            if (spi_we && int'(spi_waddr) == i)
                regs_d[i] = spi_wdata;
        end
        spi_rdata   = (int'(spi_raddr) < NUM_REGS) ? regs_q[spi_raddr[LOC_AW-1:0]] : '0;
        loc_rdata   = (int'(loc_addr) < NUM_REGS) ? regs_q[loc_addr] : '0;
        status_byte = regs_q[STATUS_ADDR];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_q[i] <= regs_d[i];
        end
    end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
    import spi_regbank_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int STATUS_ADDR = 0,
    parameter int SYNC_STAGES = 2,
    localparam int LOC_AW     = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              ss_n,
    input  logic              sck,
    input  logic              mosi,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              loc_we,
    input  logic [LOC_AW-1:0] loc_addr,
    input  logic [BYTE_W-1:0] loc_wdata,
    output logic [BYTE_W-1:0] loc_rdata
);
    localparam int SER_W = 3;

    logic [SER_W-1:0]  ser_s;
    logic              sel, miso_bit;
    logic              spi_we;
    logic [CMD_AW-1:0] spi_waddr, spi_raddr;
    logic [BYTE_W-1:0] spi_wdata, spi_rdata, status_byte;

    spi_sync_chain #(
        .WIDTH    (SER_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b001)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({mosi, sck, ss_n}),
        .dout (ser_s)
    );

    spi_frame_engine i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cpol),
        .cpha       (cpha),
        .ss_s       (ser_s[0]),
        .sck_s      (ser_s[1]),
        .mosi_s     (ser_s[2]),
        .status_byte(status_byte),
        .rd_data    (spi_rdata),
        .rd_addr    (spi_raddr),
        .wr_en      (spi_we),
        .wr_addr    (spi_waddr),
        .wr_data    (spi_wdata),
        .sel        (sel),
        .miso_bit   (miso_bit)
    );

    spi_reg_store #(
        .NUM_REGS   (NUM_REGS),
        .STATUS_ADDR(STATUS_ADDR)
    ) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_we     (spi_we),
        .spi_waddr  (spi_waddr),
        .spi_wdata  (spi_wdata),
        .spi_raddr  (spi_raddr),
        .spi_rdata  (spi_rdata),
        .loc_we     (loc_we),
        .loc_addr   (loc_addr),
        .loc_wdata  (loc_wdata),
        .loc_rdata  (loc_rdata),
        .status_byte(status_byte)
    );

    assign miso_oe = sel;
    assign miso_o  = sel & miso_bit;
endmodule

// File: rtl/spi_regbank_checker.sv
module spi_regbank_checker #(
    parameter int NUM_REGS = 16,
    parameter int LOC_AW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n,
    input logic              miso_o,
    input logic              miso_oe,
    input logic              loc_we,
    input logic [LOC_AW-1:0] loc_addr,
    input logic [7:0]        loc_wdata,
    input logic [7:0]        loc_rdata,
    input logic              spi_we,
    input logic [6:0]        spi_waddr,
    input logic [7:0]        spi_wdata
);
    assert_release_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n && $past(ss_n) && $past(ss_n, 2)) |-> (!miso_oe && !miso_o));

    assert_drive_selected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && !$past(ss_n) && !$past(ss_n, 2)) |-> miso_oe);

    assert_single_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_we |=> !spi_we);

    assert_commit_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_we && int'(spi_waddr) < NUM_REGS && int'(loc_addr) == int'(spi_waddr))
        |=> (loc_addr != $past(loc_addr) || loc_rdata == $past(spi_wdata)));

    assert_ignore_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_we && int'(spi_waddr) >= NUM_REGS && !loc_we)
        |=> (loc_addr != $past(loc_addr) || $stable(loc_rdata)));

    assert_local_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_we && !spi_we)
        |=> (loc_addr != $past(loc_addr) || loc_rdata == $past(loc_wdata)));
endmodule

bind spi_regbank_slave spi_regbank_checker #(
    .NUM_REGS(NUM_REGS),
    .LOC_AW  (LOC_AW)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ss_n     (ss_n),
    .miso_o   (miso_o),
    .miso_oe  (miso_oe),
    .loc_we   (loc_we),
    .loc_addr (loc_addr),
    .loc_wdata(loc_wdata),
    .loc_rdata(loc_rdata),
    .spi_we   (spi_we),
    .spi_waddr(spi_waddr),
    .spi_wdata(spi_wdata)
);

// File: tb/test_spi_regbank_slave.sv
module test_spi_regbank_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int NVEC       = 8;
    // entry: {mode[1:0]={cpol,cpha}, addr[6:0], wdata[7:0], expected read[7:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {2'd0, 7'd1,   8'h3C, 8'h3C},
        {2'd1, 7'd2,   8'hC3, 8'hC3},
        {2'd2, 7'd3,   8'h5A, 8'h5A},
        {2'd3, 7'd15,  8'h81, 8'h81},
        {2'd0, 7'd20,  8'hFF, 8'h00},
        {2'd3, 7'd127, 8'h7E, 8'h00},
        {2'd1, 7'd1,   8'h00, 8'h00},
        {2'd2, 7'd0,   8'h96, 8'h96}
    };

    logic       clk = 0, rst_n = 0;
    logic       cpol = 0, cpha = 0, ss_n = 1, sck = 0, mosi = 0;
    logic       miso_o, miso_oe, loc_we = 0;
    logic [3:0] loc_addr = 0;
    logic [7:0] loc_wdata = 0, loc_rdata;

    logic [7:0] tx_buf [8];
    logic [7:0] rx_buf [8];
    logic [7:0] model [16];
    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regbank_slave i_spi_regbank_slave (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .ss_n(ss_n),
        .sck(sck), .mosi(mosi), .miso_o(miso_o), .miso_oe(miso_oe),
        .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .loc_rdata(loc_rdata)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        cpol = m[1]; cpha = m[0]; sck = m[1];
        tick(4);
    endtask

    task automatic shift_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            if (!cpha) begin
                mosi = tx[i]; tick(HALF);
                rx[i] = miso_o; sck = ~cpol; tick(HALF);
                sck = cpol;
            end else begin
                mosi = tx[i]; sck = ~cpol; tick(HALF);
                rx[i] = miso_o; sck = cpol; tick(HALF);
            end
        end
    endtask

    task automatic run_txn(input int n);
        logic [7:0] r;
        ss_n = 0; tick(HALF);
        for (int k = 0; k < n; k++) begin
            shift_bits(tx_buf[k], 8, r);
            rx_buf[k] = r;
        end
        tick(HALF); ss_n = 1; tick(2*HALF);
    endtask

    task automatic peek(input int a, output logic [7:0] v);
        loc_addr = 4'(a); tick(1); v = loc_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 00 expected 01");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [1:0] m;
        logic [6:0] a;
        logic [7:0] wd, ex;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        tick(5); rst_n = 1; tick(5);

        // R11: reset state
        chk(miso_oe == 1'b0, "R11 miso_oe", {7'd0, miso_oe}, 8'h00);
        for (int i = 0; i < 16; i++) begin
            peek(i, v);
            chk(v == 8'h00, "R11 reg reset", v, 8'h00);
        end

        // R10: local write of the status register
        loc_addr = 4'd0; loc_wdata = 8'hA5; loc_we = 1; tick(1); loc_we = 0;
        model[0] = 8'hA5;
        chk(loc_rdata == 8'hA5, "R10 local write", loc_rdata, 8'hA5);

        // Table: write then read back in each mode
        for (int n = 0; n < NVEC; n++) begin
            {m, a, wd, ex} = VEC[n];
            set_mode(m);
            tx_buf[0] = {1'b0, a}; tx_buf[1] = wd;
            run_txn(2);
            chk(rx_buf[0] == model[0], "R3 status on write cmd", rx_buf[0], model[0]);
            if (a < 7'd16) model[a[3:0]] = wd;
            if (a < 7'd16) begin
                peek(int'(a), v);
                chk(v == wd, "R5 committed write", v, wd);
            end
            tx_buf[0] = {1'b1, a}; tx_buf[1] = 8'h00;
            run_txn(2);
            chk(rx_buf[0] == model[0], "R3 status on read cmd", rx_buf[0], model[0]);
            chk(rx_buf[1] == ex, "R2 R4 R6 R8 read back", rx_buf[1], ex);
        end

        // R7: burst write in mode 0, burst read in mode 3
        set_mode(2'd0);
        tx_buf[0] = 8'h04; tx_buf[1] = 8'h11; tx_buf[2] = 8'h22; tx_buf[3] = 8'h33;
        run_txn(4);
        model[4] = 8'h11; model[5] = 8'h22; model[6] = 8'h33;
        set_mode(2'd3);
        tx_buf[0] = 8'h84; tx_buf[1] = 0; tx_buf[2] = 0; tx_buf[3] = 0; tx_buf[4] = 0;
        run_txn(5);
        chk(rx_buf[1] == 8'h11, "R7 burst byte0", rx_buf[1], 8'h11);
        chk(rx_buf[2] == 8'h22, "R7 burst byte1", rx_buf[2], 8'h22);
        chk(rx_buf[3] == 8'h33, "R7 burst byte2", rx_buf[3], 8'h33);
        chk(rx_buf[4] == model[7], "R7 burst byte3", rx_buf[4], model[7]);

        // R8: burst crossing the top of the bank, and wrap 127 -> 0
        tx_buf[0] = 8'h8F; tx_buf[1] = 0; tx_buf[2] = 0;
        run_txn(3);
        chk(rx_buf[1] == model[15], "R8 last reg", rx_buf[1], model[15]);
        chk(rx_buf[2] == 8'h00, "R8 above bank", rx_buf[2], 8'h00);
        tx_buf[0] = 8'hFF;
        run_txn(3);
        chk(rx_buf[1] == 8'h00, "R8 addr 127", rx_buf[1], 8'h00);
        chk(rx_buf[2] == model[0], "R7 wrap to 0", rx_buf[2], model[0]);

        // R9: abort mid-byte during a write to register 5
        set_mode(2'd1);
        ss_n = 0; tick(HALF);
        shift_bits(8'h05, 8, v);
        shift_bits(8'hEE, 4, v);
        ss_n = 1; tick(2*HALF);
        peek(5, v);
        chk(v == model[5], "R9 partial byte discarded", v, model[5]);
        tx_buf[0] = 8'h85; tx_buf[1] = 0;
        run_txn(2);
        chk(rx_buf[0] == model[0], "R9 restart with command", rx_buf[0], model[0]);
        chk(rx_buf[1] == model[5], "R9 reg after abort", rx_buf[1], model[5]);

        // R1: activity while deselected is ignored; enable follows select
        set_mode(2'd0);
        for (int i = 0; i < 16; i++) begin
            mosi = i[0]; sck = ~sck; tick(HALF);
            chk(miso_oe == 1'b0 && miso_o == 1'b0, "R1 released while idle", {6'd0, miso_oe, miso_o}, 8'h00);
        end
        sck = 1'b0; tick(4);
        peek(1, v);
        chk(v == model[1], "R1 no register change", v, model[1]);
        ss_n = 0; tick(4);
        chk(miso_oe == 1'b1, "R1 driven when selected", {7'd0, miso_oe}, 8'h01);
        ss_n = 1; tick(4);
        chk(miso_oe == 1'b0, "R1 released after deselect", {7'd0, miso_oe}, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule